// File: doc/BRIEF.md
# Streaming 2x2 Video Downscaler

This block shrinks a video stream to half its width and half its height, so each output frame covers one quarter of the input area (a 1920x1080 input becomes 960x540). Pixels arrive and leave on 32-bit AXI4-Stream video ports. Start of frame travels on `tuser` and end of line on `tlast`. Each output pixel is the rounded mean of a 2x2 block of input pixels, computed separately for each of the three 8-bit colour components.

The block works in a single pass, so it can sit directly in front of a frame-buffer writer. It keeps one output line of horizontal pair sums in on-chip storage. Even input lines fill that storage. Odd input lines read it back and complete each 2x2 block. Input frames must have an even width and an even height, and the width must not exceed `MAX_WIDTH`. Both ports honour backpressure.

Top module: `ds2x2_scaler`

## Requirements
- R1: After reset, `m_tvalid` is 0 and `s_tready` is 1.
- R2: Each output component is (a+b+c+d+2)>>2, where a to d are the matching components of the four input pixels. Components sit in bits [7:0], [15:8] and [23:16]. Input bits [31:24] are ignored, and output bits [31:24] are 0.
- R3: Output pixel x of output line j is built from input columns 2x and 2x+1 of input lines 2j and 2j+1. A WxH input frame yields (W/2)x(H/2) output pixels.
- R4: Beats on even input lines (line 0 is the first line) produce no output pixel.
- R5: `m_tuser` is 1 on the first output pixel of a frame and 0 on every other output pixel.
- R6: `m_tlast` is 1 on the last output pixel of each output line and 0 otherwise.
- R7: An accepted input beat with `s_tuser`=1 is treated as line 0, column 0 of a new frame, and any partial lines before it are discarded.
- R8: `s_tready` is 0 only while an output pixel is waiting (`m_tvalid`=1) and `m_tready` is 0.
- R9: While `m_tvalid`=1 and `m_tready`=0, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values.
- R10: An output pixel becomes valid on the clock edge after the input beat that completes its 2x2 block is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 32 | Input pixel |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block can take an input beat |
| s_tuser | input | 1 | Input start of frame |
| s_tlast | input | 1 | Input end of line |
| m_tdata | output | 32 | Output pixel |
| m_tvalid | output | 1 | Output pixel valid |
| m_tready | input | 1 | Downstream can take the output pixel |
| m_tuser | output | 1 | Output start of frame |
| m_tlast | output | 1 | Output end of line |

## Verification
The checker watches the stream handshake on every cycle. It confirms that an idle output never blocks the input, that no beat is taken during a stall, that a stalled pixel and its markers stay frozen, that a completed block appears one edge later, and that even-line beats stay silent. The arithmetic, the rounding, and the mapping of input columns and lines onto output pixels are only visible through the bench's frames. The same holds for the placement of the frame and line markers and for the discard of a partial frame on resynchronisation. The bench compares every captured output pixel against its own model of the 2x2 mean.

// File: rtl/ds2x2_pkg.sv
package ds2x2_pkg;
  localparam int unsigned PIX_COMP_W = 8;
  localparam int unsigned PIX_NCOMP  = 3;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned ACT_W      = PIX_COMP_W * PIX_NCOMP;
  localparam int unsigned HSUM_W     = PIX_COMP_W + 1;
  localparam int unsigned QSUM_W     = PIX_COMP_W + 2;

  typedef logic [PIX_COMP_W-1:0]           comp_t;
  typedef logic [HSUM_W-1:0]               hsum_t;
  typedef logic [QSUM_W-1:0]               qsum_t;
  typedef logic [ACT_W-1:0]                pix_t;
  typedef hsum_t [PIX_NCOMP-1:0]           hpair_t;

  // one colour component out of the active part of a pixel word
  function automatic comp_t get_comp(input pix_t w, input int unsigned idx);
    return w[idx*PIX_COMP_W +: PIX_COMP_W];
  endfunction

  // horizontal sum of two neighbouring components
  function automatic hsum_t add_pair(input comp_t a, input comp_t b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // rounded quarter of two horizontal sums
  function automatic comp_t round_quarter(input hsum_t upper, input hsum_t lower);
    qsum_t s;
    s = {1'b0, upper} + {1'b0, lower} + qsum_t'(2);
    return s[QSUM_W-1:2];
  endfunction
endpackage

// File: rtl/ds2x2_pos_track.sv
// Column / line-parity tracker. The eff_* outputs already account for a
// start-of-frame marker on the current beat.
module ds2x2_pos_track #(
  parameter int unsigned COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eol,
  output logic [COL_W-1:0] eff_col,
  output logic             eff_odd,
  output logic             eff_top
);
  logic [COL_W-1:0] col_q;
  logic             odd_q;
  logic             top_q;

  assign eff_col = sof ? '0   : col_q;
  assign eff_odd = sof ? 1'b0 : odd_q;
  assign eff_top = sof ? 1'b1 : top_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      odd_q <= 1'b0;
      top_q <= 1'b1;
    end else if (beat) begin
      if (eol) begin
        col_q <= '0;
        odd_q <= ~eff_odd;
        top_q <= eff_top & ~eff_odd;
      end else begin
        col_q <= eff_col + COL_W'(1);
        odd_q <= eff_odd;
        top_q <= eff_top;
      end
    end
  end
endmodule

// File: rtl/ds2x2_line_store.sv
// One output line of horizontal pair sums; asynchronous read.
module ds2x2_line_store
  import ds2x2_pkg::*;
#(
  parameter int unsigned DEPTH  = 960,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  hpair_t            wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output hpair_t            rd_data
);
  hpair_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ds2x2_out_reg.sv
// Single output slot with stream handshake.
module ds2x2_out_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          load_user,
  input  logic          load_last,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          user,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      user  <= 1'b0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      user  <= load_user;
      last  <= load_last;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ds2x2_scaler.sv
module ds2x2_scaler
  import ds2x2_pkg::*;
#(
  parameter int unsigned MAX_WIDTH = 1920
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] s_tdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic             s_tuser,
  input  logic             s_tlast,
  output logic [BUS_W-1:0] m_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic             m_tuser,
  output logic             m_tlast
);
  localparam int unsigned COL_W     = $clog2(MAX_WIDTH);
  localparam int unsigned BUF_DEPTH = MAX_WIDTH / 2;
  localparam int unsigned ADDR_W    = COL_W - 1;

  // named internal events (also observed by the checker)
  logic             beat_acc;
  logic             pair_done;
  logic             line_wr;
  logic             quad_done;
  logic [COL_W-1:0] pos_col;
  logic             pos_odd;
  logic             pos_top;

  pix_t             pix_in;
  pix_t             h_pix;
  logic             unused_top_byte;
  hpair_t           pair_now;
  hpair_t           pair_above;
  logic [ADDR_W-1:0] buf_addr;
  logic [BUS_W-1:0] out_word;
  logic             out_first;

  assign pix_in          = s_tdata[ACT_W-1:0];
  assign unused_top_byte = ^s_tdata[BUS_W-1:ACT_W];

  assign s_tready  = !m_tvalid || m_tready;
  assign beat_acc  = s_tvalid && s_tready;
  assign pair_done = beat_acc && pos_col[0];
  assign line_wr   = pair_done && !pos_odd;
  assign quad_done = pair_done && pos_odd;
  assign buf_addr  = pos_col[COL_W-1:1];
  assign out_first = pos_top && (pos_col == COL_W'(1));

  ds2x2_pos_track #(.COL_W(COL_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat_acc),
    .sof     (s_tuser),
    .eol     (s_tlast),
    .eff_col (pos_col),
    .eff_odd (pos_odd),
    .eff_top (pos_top)
  );

  // left pixel of the current horizontal pair
  always_ff @(posedge clk) begin
    if (!rst_n)                      h_pix <= '0;
    else if (beat_acc && !pos_col[0]) h_pix <= pix_in;
  end

  ds2x2_line_store #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) u_line (
    .clk     (clk),
    .wr_en   (line_wr),
    .wr_addr (buf_addr),
    .wr_data (pair_now),
    .rd_addr (buf_addr),
    .rd_data (pair_above)
  );

  assign out_word[BUS_W-1:ACT_W] = '0;

  for (genvar g = 0; g < PIX_NCOMP; g++) begin : g_comp
    assign pair_now[g] = add_pair(get_comp(h_pix, g), get_comp(pix_in, g));
    assign out_word[g*PIX_COMP_W +: PIX_COMP_W] = round_quarter(pair_above[g], pair_now[g]);
  end

  ds2x2_out_reg #(.DW(BUS_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (quad_done),
    .load_data (out_word),
    .load_user (out_first),
    .load_last (s_tlast),
    .ready     (m_tready),
    .valid     (m_tvalid),
    .data      (m_tdata),
    .user      (m_tuser),
    .last      (m_tlast)
  );
endmodule

// File: rtl/ds2x2_scaler_chk.sv
module ds2x2_scaler_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_tready,
  input logic          m_tvalid,
  input logic          m_tready,
  input logic [DW-1:0] m_tdata,
  input logic          m_tuser,
  input logic          m_tlast,
  input logic          beat_acc,
  input logic          quad_done,
  input logic          eff_odd
);
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tvalid |-> s_tready); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |-> !beat_acc); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast))); // R9

  AST_BLOCK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    quad_done |=> m_tvalid); // R10

  AST_EVEN_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc && !eff_odd && !m_tvalid) |=> !m_tvalid); // R4
endmodule

bind ds2x2_scaler ds2x2_scaler_chk #(.DW(32)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_tready  (s_tready),
  .m_tvalid  (m_tvalid),
  .m_tready  (m_tready),
  .m_tdata   (m_tdata),
  .m_tuser   (m_tuser),
  .m_tlast   (m_tlast),
  .beat_acc  (beat_acc),
  .quad_done (quad_done),
  .eff_odd   (pos_odd)
);

// File: tb/ds2x2_scaler_bench.sv
module ds2x2_scaler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic        s_tuser = 1'b0;
  logic        s_tlast = 1'b0;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        m_tuser;
  logic        m_tlast;

  always #10 clk = ~clk;

  ds2x2_scaler u_ds2x2_scaler (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tuser(s_tuser), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tuser(m_tuser), .m_tlast(m_tlast)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] cap_data [64];
  logic        cap_user [64];
  logic        cap_last [64];
  int          cap_n = 0;
  int          bp_mode = 0;   // 0 ready, 1 pseudo-random, 2 held low
  logic [7:0]  lfsr = 8'hA5;

  // downstream driver and output monitor
  always @(negedge clk) begin
    if (bp_mode == 0)      m_tready = 1'b1;
    else if (bp_mode == 2) m_tready = 1'b0;
    else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m_tready = lfsr[0];
    end
    #2;
    if (rst_n && m_tvalid && m_tready && cap_n < 64) begin
      cap_data[cap_n] = m_tdata;
      cap_user[cap_n] = m_tuser;
      cap_last[cap_n] = m_tlast;
      cap_n++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic u, input logic l);
    @(negedge clk);
    s_tdata = d; s_tuser = u; s_tlast = l; s_tvalid = 1'b1;
    #1;
    while (!s_tready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // bench model of the 2x2 mean: integer division of the rounded sum
  function automatic logic [31:0] mean4(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 3; k++) begin
      int s;
      s = int'(a[8*k +: 8]) + int'(b[8*k +: 8]) + int'(c[8*k +: 8]) + int'(d[8*k +: 8]);
      r[8*k +: 8] = 8'((s + 2) / 4);
    end
    return r;
  endfunction

  function automatic logic [31:0] pix(input int r, input int c);
    return {8'h5A, 8'(r * 16 + c), 8'(c * 37 + r), 8'(255 - r * 9 - c)};
  endfunction

  task automatic send_quad(input logic [31:0] p0, input logic [31:0] p1,
                           input logic [31:0] p2, input logic [31:0] p3);
    send(p0, 1'b1, 1'b0);
    send(p1, 1'b0, 1'b1);
    send(p2, 1'b0, 1'b0);
    send(p3, 1'b0, 1'b1);
  endtask

  // top-left, top-right, bottom-left, bottom-right, expected
  localparam logic [31:0] VEC [7][5] = '{
    '{32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00FFFFFF},
    '{32'h00010203, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000101},
    '{32'h00102030, 32'h00102030, 32'h00102030, 32'h00102030, 32'h00102030},
    '{32'h000000FF, 32'h00000000, 32'h00000000, 32'h00000001, 32'h00000040},
    '{32'h00FE0000, 32'h00FF0000, 32'h00FF0000, 32'h00FF0000, 32'h00FF0000},
    '{32'hAB000006, 32'hCD000006, 32'h00000006, 32'h00000007, 32'h00000006}
  };

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    #3;
    check("R1 m_tvalid after reset", 32'(m_tvalid), 32'd0);
    check("R1 s_tready after reset", 32'(s_tready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: empty output never blocks the input, even with m_tready low
    bp_mode = 2;
    repeat (2) @(negedge clk);
    #3;
    check("R8 ready while empty and m_tready low", 32'(s_tready), 32'd1);
    bp_mode = 0;

    // table of single-block frames: R2 R3 R5 R6
    for (int i = 0; i < 7; i++) begin
      cap_n = 0;
      send_quad(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      idle(3);
      check($sformatf("R3 count vec%0d", i), 32'(cap_n), 32'd1);
      check($sformatf("R2 data vec%0d", i), cap_data[0], VEC[i][4]);
      check($sformatf("R5 user vec%0d", i), 32'(cap_user[0]), 32'd1);
      check($sformatf("R6 last vec%0d", i), 32'(cap_last[0]), 32'd1);
    end

    // R10: output valid exactly one edge after the completing beat
    cap_n = 0;
    send(VEC[3][0], 1'b1, 1'b0);
    send(VEC[3][1], 1'b0, 1'b1);
    send(VEC[3][2], 1'b0, 1'b0);
    send(VEC[3][3], 1'b0, 1'b1);
    check("R10 not valid before edge", 32'(m_tvalid), 32'd0);
    @(negedge clk);
    #3;
    check("R10 valid one edge later", 32'(m_tvalid), 32'd1);
    idle(3);

    // 8x4 frame under pseudo-random backpressure: R2 R3 R5 R6
    cap_n = 0;
    bp_mode = 1;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        send(pix(r, c), (r == 0 && c == 0), (c == 7));
    bp_mode = 0;
    idle(10);
    check("R3 count 8x4", 32'(cap_n), 32'd8);
    for (int k = 0; k < 8; k++) begin
      int j;
      int x;
      j = k / 4;
      x = k % 4;
      check($sformatf("R3 data 8x4 px%0d", k), cap_data[k],
            mean4(pix(2*j, 2*x), pix(2*j, 2*x+1), pix(2*j+1, 2*x), pix(2*j+1, 2*x+1)));
      check($sformatf("R5 user 8x4 px%0d", k), 32'(cap_user[k]), 32'(k == 0));
      check($sformatf("R6 last 8x4 px%0d", k), 32'(cap_last[k]), 32'(x == 3));
    end

    // R4 then R7: even line is silent; a mid-frame start marker restarts
    cap_n = 0;
    for (int c = 0; c < 8; c++) send(pix(5, c), (c == 0), (c == 7));
    idle(4);
    check("R4 no output after even line", 32'(cap_n), 32'd0);
    check("R4 m_tvalid after even line", 32'(m_tvalid), 32'd0);
    send(pix(6, 0), 1'b0, 1'b0);
    send_quad(VEC[4][0], VEC[4][1], VEC[4][2], VEC[4][3]);
    idle(4);
    check("R7 count after resync", 32'(cap_n), 32'd1);
    check("R7 data after resync", cap_data[0], VEC[4][4]);
    check("R7 user after resync", 32'(cap_user[0]), 32'd1);

    // R8 R9: stall with m_tready low
    cap_n = 0;
    bp_mode = 2;
    send_quad(VEC[6][0], VEC[6][1], VEC[6][2], VEC[6][3]);
    idle(0);
    #3;
    check("R8 s_tready low while stalled", 32'(s_tready), 32'd0);
    check("R9 valid while stalled", 32'(m_tvalid), 32'd1);
    held = m_tdata;
    repeat (3) @(negedge clk);
    #3;
    check("R9 data held", m_tdata, held);
    check("R9 valid held", 32'(m_tvalid), 32'd1);
    check("R9 user held", 32'(m_tuser), 32'd1);
    bp_mode = 0;
    idle(3);
    check("R9 released count", 32'(cap_n), 32'd1);
    check("R9 released data", cap_data[0], VEC[6][4]);

    summary();
    $finish;
  end
endmodule